// File: doc/BRIEF.md
# Serial In-System Programming Target

This block is the target-side controller through which an external programmer loads a small program memory (16-bit words) and a small data memory (bytes) over a three-wire serial link. The link consists of a serial clock input, a serial data input and a serial data output. It operates only while a separate active-low programming-reset input is held low. A local system clock oversamples the serial clock. Every instruction is a 32-bit frame sent as four bytes, most significant bit first. The block decodes the frame and acts on the two register-file memories.

The programmer must first send the enable instruction. After that it can erase both arrays, write bytes into either memory, and read them back. Writes and erases raise a busy pin for a fixed number of system cycles. The serial link has no handshake, so there is no back-pressure: a frame that completes while busy is high is dropped. The programmer has to watch the busy pin, or wait out the busy time, before it sends the next write or read.

Top module: `isp_target`

## Requirements
- R1: The link is active only while `isp_rst_n` is low. When `isp_rst_n` goes high, the frame bit counter returns to zero, the enabled state clears and `sdo` drives 0, so the next frame after a new low starts at bit 31 and is rejected unless it is an enable.
- R2: Until an enable frame has been accepted, the block rejects every other frame. Writes and erases leave both memories unchanged and do not raise busy, and reads return 0x00 in byte 4.
- R3: The enable frame is byte 1 = 0xAC with byte 2 = 0x53. While byte 3 is shifted in, `sdo` returns 0x53.
- R4: `sdi` is sampled on each rising edge of `sck`, 32 bits per frame, MSB first. `sdo` changes after falling edges only. For every frame, byte 3 out is a copy of byte 2 in, and byte 4 out carries the read data, MSB first.
- R5: The erase frame (0xAC, 0x80) sets every program word to 0xFFFF and every data byte to 0xFF.
- R6: A program write uses opcode 0x40 for the low byte or 0x48 for the high byte, followed by a 16-bit word address and a data byte. It can only clear bits: new = old AND data.
- R7: A program read uses opcode 0x20 for the low byte or 0x28 for the high byte, followed by a 16-bit address. It returns that byte in byte 4.
- R8: A data write uses opcode 0xC0, a 16-bit address and a data byte. It erases the location itself first, so the stored byte equals the data byte whatever the old value. A data read uses opcode 0xA0 and returns the byte in byte 4.
- R9: After a write or erase, `busy` is high for BUSY_CYCLES system cycles. A frame that completes while busy is high has no effect, and a read whose byte 4 is loaded while busy is high returns 0x00.
- R10: Address bits above log2 of the array depth are ignored, so addresses alias modulo the array depth.
- R11: Frames are received correctly when every `sck` high phase and low phase lasts at least 3 system cycles with `clk_slow`=1, or at least 4 system cycles with `clk_slow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low; fills both memories with 0xFF |
| isp_rst_n | input | 1 | Programming reset; the serial link is active while this is low |
| clk_slow | input | 1 | 1 when the system clock is below 12 MHz; selects the minimum `sck` phase width |
| sck | input | 1 | Serial clock from the programmer |
| sdi | input | 1 | Serial data into the block |
| sdo | output | 1 | Serial data out of the block |
| busy | output | 1 | High while a write or erase is in progress |

## Verification
The assertions assume three things about the inputs:
- Every `sck` level is held for the minimum phase width set by `clk_slow`.
- `sdi` changes only during `sck` low phases.
- `isp_rst_n` changes only while `sck` is low.

The stimulus drives every bit the same way. It sets `sck` low and places `sdi` at the same moment, holds both for one half period, and then raises `sck` for another half period. Half periods are 3 cycles in slow mode and 4 in fast mode, which are exactly the minimum widths. The programming reset is toggled only with `sck` low, including once in the middle of a frame.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam int FRAME_BITS = 32;

  localparam logic [7:0] OP_CTRL    = 8'hAC;
  localparam logic [7:0] SUB_ENABLE = 8'h53;
  localparam logic [7:0] SUB_ERASE  = 8'h80;
  localparam logic [7:0] OP_PW_LO   = 8'h40;
  localparam logic [7:0] OP_PW_HI   = 8'h48;
  localparam logic [7:0] OP_PR_LO   = 8'h20;
  localparam logic [7:0] OP_PR_HI   = 8'h28;
  localparam logic [7:0] OP_DW      = 8'hC0;
  localparam logic [7:0] OP_DR      = 8'hA0;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_ENABLE, CMD_ERASE, CMD_PWRITE, CMD_PREAD, CMD_DWRITE, CMD_DREAD
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic [7:0] op, input logic [7:0] sub);
    cmd_e c;
    c = CMD_NONE;
    if (op == OP_CTRL && sub == SUB_ENABLE)      c = CMD_ENABLE;
    else if (op == OP_CTRL && sub == SUB_ERASE)  c = CMD_ERASE;
    else if (op == OP_PW_LO || op == OP_PW_HI)   c = CMD_PWRITE;
    else if (op == OP_PR_LO || op == OP_PR_HI)   c = CMD_PREAD;
    else if (op == OP_DW)                        c = CMD_DWRITE;
    else if (op == OP_DR)                        c = CMD_DREAD;
    return c;
  endfunction
endpackage

// File: rtl/isp_sck_sync.sv
module isp_sck_sync #(
  parameter int PHASE_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic sdi,
  input  logic isp_rst_n,
  input  logic clk_slow,
  output logic active,
  output logic rise,
  output logic fall,
  output logic sdi_s
);
  logic [2:0] sck_q;
  logic [1:0] sdi_q;
  logic [1:0] rst_q;
  logic [PHASE_W-1:0] phase_len;
  logic sck_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      sdi_q <= '0;
      rst_q <= 2'b11;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      sdi_q <= {sdi_q[0], sdi};
      rst_q <= {rst_q[0], isp_rst_n};
    end
  end

  assign active   = !rst_q[1];
  assign sck_edge = sck_q[1] ^ sck_q[2];
  assign rise     = active && sck_q[1] && !sck_q[2];
  assign fall     = active && !sck_q[1] && sck_q[2];
  assign sdi_s    = sdi_q[1];

  // length of the level currently held by the synchronized clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  phase_len <= '1;
    else if (sck_edge)           phase_len <= PHASE_W'(1);
    else if (phase_len != '1)    phase_len <= phase_len + 1'b1;
  end

  AST_SCK_PHASE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sck_edge) |-> (phase_len >= (clk_slow ? PHASE_W'(3) : PHASE_W'(4)))); // R11
endmodule

// File: rtl/isp_frame.sv
module isp_frame
  import isp_pkg::*;
#(
  localparam int CNT_W = $clog2(FRAME_BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active,
  input  logic                  rise,
  input  logic                  fall,
  input  logic                  sdi_s,
  input  logic [7:0]            rd_byte,
  output logic [FRAME_BITS-1:0] rx_sr,
  output logic [CNT_W-1:0]      bit_cnt,
  output logic                  frame_done,
  output logic                  sdo
);
  logic [7:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr      <= '0;
      bit_cnt    <= '0;
      tx_sr      <= '0;
      frame_done <= 1'b0;
    end else if (!active) begin
      rx_sr      <= '0;
      bit_cnt    <= '0;
      tx_sr      <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (rise) begin
        rx_sr <= {rx_sr[FRAME_BITS-2:0], sdi_s};
        if (bit_cnt == CNT_W'(FRAME_BITS-1)) begin
          bit_cnt    <= '0;
          frame_done <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (fall) begin
        if (bit_cnt == CNT_W'(FRAME_BITS-16))     tx_sr <= rx_sr[7:0];
        else if (bit_cnt == CNT_W'(FRAME_BITS-8)) tx_sr <= rd_byte;
        else                                      tx_sr <= {tx_sr[6:0], 1'b0};
      end
    end
  end

  assign sdo = tx_sr[7];

  AST_SDO_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !sdo); // R1
  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !$past(fall) && $past(active)) |-> $stable(sdo)); // R4
endmodule

// File: rtl/isp_regfile.sv
module isp_regfile #(
  parameter int WORDS      = 64,
  parameter int WIDTH      = 8,
  parameter bit CLEAR_ONLY = 1'b0,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             erase,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wmask,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata,
  input  logic             lock_busy,
  input  logic             lock_off
);
  logic [WIDTH-1:0] mem [WORDS];
  logic [WIDTH-1:0] merged;

  generate
    if (CLEAR_ONLY) begin : g_clear_only
      assign merged = mem[waddr] & wdata;
    end else begin : g_self_erase
      assign merged = wdata;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (erase) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (we) begin
      mem[waddr] <= (mem[waddr] & ~wmask) | (merged & wmask);
    end
  end

  assign rdata = mem[raddr];

  AST_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_busy |=> ($stable(mem[0]) && $stable(mem[WORDS-1]))); // R9
  AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    lock_off |=> ($stable(mem[0]) && $stable(mem[WORDS-1]))); // R2
  AST_ERASE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> ((&mem[0]) && (&mem[WORDS-1]))); // R5
endmodule

// File: rtl/isp_target.sv
module isp_target
  import isp_pkg::*;
#(
  parameter int PMEM_WORDS  = 64,
  parameter int DMEM_BYTES  = 64,
  parameter int BUSY_CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic isp_rst_n,
  input  logic clk_slow,
  input  logic sck,
  input  logic sdi,
  output logic sdo,
  output logic busy
);
  localparam int PA_W   = $clog2(PMEM_WORDS);
  localparam int DA_W   = $clog2(DMEM_BYTES);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam int CNT_W  = $clog2(FRAME_BITS);

  logic                  active, rise, fall, sdi_s;
  logic [FRAME_BITS-1:0] rx_sr;
  logic [CNT_W-1:0]      bit_cnt;
  logic                  frame_done;
  logic [7:0]            rd_byte;
  logic                  enabled;
  logic [BUSY_W-1:0]     busy_cnt;
  logic [15:0]           p_rdata;
  logic [7:0]            d_rdata;
  cmd_e                  exec_cmd;
  logic                  accept, do_enable, do_erase, do_pw, do_dw;
  logic [7:0]            rd_op;
  logic                  unused_bits;

  isp_sck_sync i_sync (
    .clk, .rst_n, .sck, .sdi, .isp_rst_n, .clk_slow,
    .active, .rise, .fall, .sdi_s
  );

  isp_frame i_frame (
    .clk, .rst_n, .active, .rise, .fall, .sdi_s, .rd_byte,
    .rx_sr, .bit_cnt, .frame_done, .sdo
  );

  // execute on the cycle the 32nd bit lands; rx_sr then holds the frame
  assign exec_cmd  = decode_cmd(rx_sr[31:24], rx_sr[23:16]);
  assign busy      = (busy_cnt != '0);
  assign accept    = frame_done && !busy;
  assign do_enable = accept && (exec_cmd == CMD_ENABLE);
  assign do_erase  = accept && enabled && (exec_cmd == CMD_ERASE);
  assign do_pw     = accept && enabled && (exec_cmd == CMD_PWRITE);
  assign do_dw     = accept && enabled && (exec_cmd == CMD_DWRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled  <= 1'b0;
      busy_cnt <= '0;
    end else begin
      if (!active)        enabled <= 1'b0;
      else if (do_enable) enabled <= 1'b1;
      if (do_erase || do_pw || do_dw) busy_cnt <= BUSY_W'(BUSY_CYCLES);
      else if (busy)                  busy_cnt <= busy_cnt - 1'b1;
    end
  end

  isp_regfile #(.WORDS(PMEM_WORDS), .WIDTH(16), .CLEAR_ONLY(1'b1)) i_pmem (
    .clk, .rst_n,
    .erase     (do_erase),
    .we        (do_pw),
    .waddr     (rx_sr[8 +: PA_W]),
    .wmask     ((rx_sr[31:24] == OP_PW_HI) ? 16'hFF00 : 16'h00FF),
    .wdata     ({rx_sr[7:0], rx_sr[7:0]}),
    .raddr     (rx_sr[PA_W-1:0]),
    .rdata     (p_rdata),
    .lock_busy (busy),
    .lock_off  (!enabled)
  );

  isp_regfile #(.WORDS(DMEM_BYTES), .WIDTH(8), .CLEAR_ONLY(1'b0)) i_dmem (
    .clk, .rst_n,
    .erase     (do_erase),
    .we        (do_dw),
    .waddr     (rx_sr[8 +: DA_W]),
    .wmask     (8'hFF),
    .wdata     (rx_sr[7:0]),
    .raddr     (rx_sr[DA_W-1:0]),
    .rdata     (d_rdata),
    .lock_busy (busy),
    .lock_off  (!enabled)
  );

  // read path: sampled by the frame unit when 24 bits have arrived
  assign rd_op = rx_sr[23:16];
  always_comb begin
    rd_byte = '0;
    if (enabled && !busy) begin
      if (rd_op == OP_PR_LO)      rd_byte = p_rdata[7:0];
      else if (rd_op == OP_PR_HI) rd_byte = p_rdata[15:8];
      else if (rd_op == OP_DR)    rd_byte = d_rdata;
    end
  end

  assign unused_bits = ^{rx_sr};

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> ((bit_cnt == '0) && !enabled)); // R1
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && busy) |=> $stable(enabled)); // R9
endmodule

// File: tb/test_isp_target.sv
module test_isp_target;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int BUSY       = 500;
  localparam int NV         = 16;

  // {frame, expected byte3, expected byte4, check byte3, check byte4}
  localparam logic [49:0] VEC [NV] = '{
    {32'hAC53_0000, 8'h53, 8'h00, 2'b10},  // R3 enable echo
    {32'hAC80_0000, 8'h00, 8'h00, 2'b00},  // R5 erase
    {32'h2000_0300, 8'h00, 8'hFF, 2'b01},  // R5 pmem erased
    {32'hA000_0700, 8'h00, 8'hFF, 2'b01},  // R5 dmem erased
    {32'h4000_0312, 8'h00, 8'h00, 2'b00},  // R6 low byte write
    {32'h4800_0334, 8'h00, 8'h00, 2'b00},  // R6 high byte write
    {32'h2000_0300, 8'h00, 8'h12, 2'b01},  // R7 R4 low read
    {32'h2800_0300, 8'h00, 8'h34, 2'b01},  // R7 high read
    {32'h4000_03F0, 8'h00, 8'h00, 2'b00},  // R6 rewrite without erase
    {32'h2000_0300, 8'h00, 8'h10, 2'b01},  // R6 AND result
    {32'hC000_050F, 8'h00, 8'h00, 2'b00},  // R8 first data write
    {32'hC000_05F0, 8'h00, 8'h00, 2'b00},  // R8 overwrite self-erases
    {32'hA000_0500, 8'h00, 8'hF0, 2'b01},  // R8 data read
    {32'hA000_4500, 8'h00, 8'hF0, 2'b01},  // R10 alias of 0x05
    {32'h4800_4300, 8'h00, 8'h00, 2'b00},  // R10 aliased write to word 3
    {32'h2800_0300, 8'h00, 8'h00, 2'b01}   // R10 R6 high byte cleared
  };

  logic clk = 1'b0, rst_n = 1'b0, isp_rst_n = 1'b1, clk_slow = 1'b1;
  logic sck = 1'b0, sdi = 1'b0;
  logic sdo, busy;
  int total = 0, bad = 0, half = 3;
  bit finished = 1'b0;
  logic [7:0] b3, b4;

  always #(CLK_PERIOD/2) clk = ~clk;

  isp_target #(.PMEM_WORDS(64), .DMEM_BYTES(64), .BUSY_CYCLES(BUSY)) i_isp_target (
    .clk, .rst_n, .isp_rst_n, .clk_slow, .sck, .sdi, .sdo, .busy
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] w, output logic [7:0] o3, output logic [7:0] o4);
    o3 = '0;
    o4 = '0;
    for (int i = 31; i >= 0; i--) begin
      sck = 1'b0;
      sdi = w[i];
      repeat (half) @(negedge clk);
      if (i >= 8 && i <= 15) o3[i-8] = sdo;
      if (i < 8)             o4[i]   = sdo;
      sck = 1'b1;
      repeat (half) @(negedge clk);
    end
    sck = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R9 act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset sdo", {7'd0, sdo}, 8'h00);
    chk("R9 reset busy", {7'd0, busy}, 8'h00);

    isp_rst_n = 1'b0;
    repeat (6) @(negedge clk);
    // R2: writes and reads refused before enable
    xfer(32'hC000_09AA, b3, b4);
    chk("R2 no busy before enable", {7'd0, busy}, 8'h00);
    xfer(32'hA000_0900, b3, b4);
    chk("R2 read refused", b4, 8'h00);
    xfer(32'hAC53_0000, b3, b4);
    chk("R3 enable echo", b3, 8'h53);
    xfer(32'hA000_0900, b3, b4);
    chk("R2 refused write left no trace", b4, 8'hFF);

    // table walk
    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][49:18], b3, b4);
      if (VEC[i][1]) chk($sformatf("R3 table[%0d] byte3", i), b3, VEC[i][17:10]);
      if (VEC[i][0]) chk($sformatf("R4 table[%0d] byte4", i), b4, VEC[i][9:2]);
      wait_idle();
    end

    // R9: frames during busy are dropped
    xfer(32'hC000_1155, b3, b4);
    chk("R9 busy after write", {7'd0, busy}, 8'h01);
    xfer(32'hA000_1100, b3, b4);
    chk("R9 read while busy", b4, 8'h00);
    xfer(32'hC000_1166, b3, b4);
    wait_idle();
    xfer(32'hA000_1100, b3, b4);
    chk("R9 write while busy dropped", b4, 8'h55);

    // R4: byte3 echoes byte2 for an ordinary read
    xfer(32'hA04C_0500, b3, b4);
    chk("R4 byte3 echo", b3, 8'h4C);

    // R1: abort mid-frame by releasing the programming reset
    for (int i = 0; i < 12; i++) begin
      sck = 1'b0;
      sdi = i[0];
      repeat (half) @(negedge clk);
      sck = 1'b1;
      repeat (half) @(negedge clk);
    end
    sck = 1'b0;
    repeat (2) @(negedge clk);
    isp_rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R1 sdo low when inactive", {7'd0, sdo}, 8'h00);
    isp_rst_n = 1'b0;
    repeat (8) @(negedge clk);
    xfer(32'hA000_1100, b3, b4);
    chk("R1 enable cleared", b4, 8'h00);
    xfer(32'hAC53_0000, b3, b4);
    chk("R1 framing realigned", b3, 8'h53);
    xfer(32'hA000_1100, b3, b4);
    chk("R1 data kept across reset", b4, 8'h55);

    // R11: fast clock setting with 4-cycle phases
    clk_slow = 1'b0;
    half = 4;
    repeat (4) @(negedge clk);
    xfer(32'hA000_1100, b3, b4);
    chk("R11 fast mode read", b4, 8'h55);
    xfer(32'hAC80_0000, b3, b4);
    wait_idle();
    xfer(32'h2800_0300, b3, b4);
    chk("R5 R11 pmem erased", b4, 8'hFF);
    xfer(32'hA000_1100, b3, b4);
    chk("R5 dmem erased", b4, 8'hFF);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule